// File: doc/BRIEF.md
# SHA-512 Schedule Small-Sigma-0 Update Unit

This unit executes one vector instruction that advances the SHA-512 message schedule by two words. Each 128-bit operand is treated as a pair of 64-bit lanes: bits 63:0 form the low lane and bits 127:64 form the high lane. The unit applies the small-sigma-0 function to two schedule words and adds each result to a lane of the destination's current value. The destination register is therefore both read and overwritten.

The lanes cross over. The new low lane is built from the destination's own high lane. The new high lane is built from the low lane of the second source. The unit also decodes a 32-bit instruction word, which has two purposes: it confirms that the word names this operation, and it extracts the source and destination register indices.

When the feature-enable input is low, or the word does not match, the unit raises an undefined-instruction flag instead of producing a result. The surrounding pipeline reads the operands from its register file and writes the result back. No condition flags are produced.

Top module: `sha512_msched_s0`

## Requirements
- R1: The function s0(x) is defined as (x rotated right by 1) XOR (x rotated right by 8) XOR (x shifted right by 7 with zero fill). The result bits 63:0 equal the destination bits 63:0 plus s0 of the destination bits 127:64.
- R2: The result bits 127:64 equal the destination bits 127:64 plus s0 of the second-source bits 63:0. The second-source bits 127:64 have no effect on any output.
- R3: Both additions are modulo 2^64 and are independent. A carry out of the low-lane addition never reaches bit 64 of the result.
- R4: An instruction word is recognised only when its bits 31:10 equal 22'h33B020, which is the word 0xCEC08000 with bits 9:0 cleared. Bits 9:0 do not affect recognition.
- R5: On an accepted operation, `res_rn` takes the instruction bits 9:5 and `res_rd` takes the instruction bits 4:0. Both are registered together with the result.
- R6: When `feat_en` is low, or the word is not recognised, an input with `in_valid` high produces `res_undef`=1 and `res_valid`=0 in the next cycle. In that case `res_data`, `res_rn` and `res_rd` keep their previous values.
- R7: The latency is one cycle, from an input with `in_valid` high to the flags and result. A cycle with `in_valid` low produces `res_valid`=0 and `res_undef`=0 in the next cycle, and leaves the data and indices unchanged.
- R8: A synchronous active-high `rst` sets `res_valid`, `res_undef`, `res_data`, `res_rn` and `res_rd` to zero.
- R9: `res_valid` and `res_undef` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word and operands are present |
| feat_en | input | 1 | SHA-512 extension feature present |
| instr | input | 32 | Instruction word |
| dst_val | input | 128 | Current destination register value |
| src_val | input | 128 | Second source register value |
| res_valid | output | 1 | Result is valid this cycle |
| res_undef | output | 1 | Undefined instruction reported this cycle |
| res_data | output | 128 | New destination value |
| res_rn | output | 5 | Source register index of the accepted operation |
| res_rd | output | 5 | Destination register index of the accepted operation |

## Verification
The unit has only one level of state, so any internal fault shows at the ports one cycle after the input that triggers it. A wrong rotation amount, a swapped lane or a leaked carry corrupts specific bits of `res_data` on the same `res_valid` pulse. The all-ones, single-bit and lane-swapped patterns make these faults visible. Decode faults show up as `res_undef` in place of `res_valid`, or the reverse, on the next cycle. A missing hold shows up as changed data or indices after a rejected or idle cycle.

// File: rtl/sha512_msched_s0.sv
module sha512_msched_s0 #(
  parameter int LANE = 64,
  parameter int ROT_A = 1,
  parameter int ROT_B = 8,
  parameter int SHR = 7,
  parameter logic [21:0] OPC_HI = 22'h33B020
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              feat_en,
  input  logic [31:0]       instr,
  input  logic [2*LANE-1:0] dst_val,
  input  logic [2*LANE-1:0] src_val,
  output logic              res_valid,
  output logic              res_undef,
  output logic [2*LANE-1:0] res_data,
  output logic [4:0]        res_rn,
  output logic [4:0]        res_rd
);
  localparam int VW = 2 * LANE;

  function automatic logic [LANE-1:0] sig0(input logic [LANE-1:0] x);
    return ((x >> ROT_A) | (x << (LANE - ROT_A))) ^
           ((x >> ROT_B) | (x << (LANE - ROT_B))) ^
           (x >> SHR);
  endfunction

  logic            hit, accept, reject;
  logic [LANE-1:0] lo_new, hi_new;

  assign hit    = (instr[31:10] == OPC_HI);
  assign accept = in_valid && feat_en && hit;
  assign reject = in_valid && !(feat_en && hit);
  assign lo_new = dst_val[LANE-1:0] + sig0(dst_val[VW-1:LANE]);
  assign hi_new = dst_val[VW-1:LANE] + sig0(src_val[LANE-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_undef <= 1'b0;
      res_data  <= '0;
      res_rn    <= '0;
      res_rd    <= '0;
    end else begin
      res_valid <= accept;
      res_undef <= reject;
      if (accept) begin
        res_data <= {hi_new, lo_new};
        res_rn   <= instr[9:5];
        res_rd   <= instr[4:0];
      end
    end
  end

  assert_flags_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(res_valid && res_undef));
  assert_valid_needs_feat_R6: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ($past(in_valid) && $past(feat_en)));
  assert_valid_needs_match_R4: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ($past(instr[31:10]) == OPC_HI));
  assert_idx_from_word_R5: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_rd == $past(instr[4:0]) && res_rn == $past(instr[9:5])));
  assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> ($stable(res_data) && $stable(res_rd) && $stable(res_rn)));
  assert_undef_needs_input_R7: assert property (@(posedge clk) disable iff (rst)
    res_undef |-> $past(in_valid));
endmodule

// File: tb/sim_sha512_msched_s0.sv
module sim_sha512_msched_s0;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         feat_en = 1'b0;
  logic [31:0]  instr = '0;
  logic [127:0] dst_val = '0;
  logic [127:0] src_val = '0;
  logic         res_valid, res_undef;
  logic [127:0] res_data;
  logic [4:0]   res_rn, res_rd;

  int checks = 0;
  int fails = 0;
  logic [127:0] exp_data = '0;
  logic [4:0]   exp_rn = '0, exp_rd = '0;
  bit           done = 1'b0;

  localparam logic [31:0] OPC = 32'hCEC08000;

  always #2 clk = ~clk;

  sha512_msched_s0 u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .feat_en(feat_en),
    .instr(instr), .dst_val(dst_val), .src_val(src_val),
    .res_valid(res_valid), .res_undef(res_undef), .res_data(res_data),
    .res_rn(res_rn), .res_rd(res_rd)
  );

  function automatic logic [63:0] ror64(input logic [63:0] x, input int n);
    return (x >> n) | (x << (64 - n));
  endfunction

  function automatic logic [63:0] ref_s0(input logic [63:0] x);
    return ror64(x, 1) ^ ror64(x, 8) ^ (x >> 7);
  endfunction

  function automatic logic [127:0] ref_res(input logic [127:0] d, input logic [127:0] s);
    logic [63:0] lo, hi;
    lo = d[63:0] + ref_s0(d[127:64]);
    hi = d[127:64] + ref_s0(s[63:0]);
    return {hi, lo};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input bit v, input bit fe, input logic [31:0] w,
                       input logic [127:0] d, input logic [127:0] s, input string req);
    bit ok;
    @(negedge clk);
    in_valid = v; feat_en = fe; instr = w; dst_val = d; src_val = s;
    ok = v && fe && (w[31:10] == OPC[31:10]);
    if (ok) begin
      exp_data = ref_res(d, s);
      exp_rn = w[9:5];
      exp_rd = w[4:0];
    end
    @(posedge clk);
    #1;
    chk({req, " valid"}, {127'd0, res_valid}, {127'd0, ok});
    chk({req, " undef"}, {127'd0, res_undef}, {127'd0, v && !ok});
    chk({req, " data"}, res_data, exp_data);
    chk({req, " idx"}, {118'd0, res_rn, res_rd}, {118'd0, exp_rn, exp_rd});
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [127:0] r1, r2;
    logic [127:0] save;
    void'($urandom(32'h5A17));
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset flags", {126'd0, res_valid, res_undef}, 128'd0);
    chk("R8 reset data", res_data, 128'd0);
    chk("R8 reset idx", {118'd0, res_rn, res_rd}, 128'd0);
    @(negedge clk); rst = 1'b0;

    issue(1, 1, OPC | {22'd0, 5'd3, 5'd7}, {128{1'b1}}, {128{1'b1}}, "R1 all-ones");
    issue(1, 1, OPC | {22'd0, 5'd31, 5'd0}, {64'h1, 64'h0}, 128'd0, "R1 single-bit high");
    issue(1, 1, OPC | {22'd0, 5'd0, 5'd31}, 128'd0, {64'h0, 64'h8000_0000_0000_0000}, "R2 single-bit src");
    issue(1, 1, OPC | {22'd0, 5'd9, 5'd4}, {64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210},
          {64'hFEDC_BA98_7654_3210, 64'h0123_4567_89AB_CDEF}, "R2 lane-swapped");
    issue(1, 1, OPC, {64'h0, 64'hFFFF_FFFF_FFFF_FFFF}, 128'd0, "R3 no-cross-carry");
    issue(1, 1, OPC, {64'hFFFF_FFFF_FFFF_FFFF, 64'h0}, {64'h0, 64'h2}, "R3 high wrap");

    r1 = {$urandom, $urandom, $urandom, $urandom};
    r2 = {$urandom, $urandom, $urandom, $urandom};
    issue(1, 1, OPC | 32'h3FF, r1, {64'h0, r2[63:0]}, "R2 src-high zero");
    save = res_data;
    issue(1, 1, OPC | 32'h3FF, r1, {~r2[127:64], r2[63:0]}, "R2 src-high ignored");
    chk("R2 src-high same result", res_data, save);

    issue(1, 0, OPC | 32'h21, r2, r1, "R6 feature off");
    issue(1, 1, OPC ^ 32'h0000_0400, r2, r1, "R4 bit10 flipped");
    issue(1, 1, OPC ^ 32'h8000_0000, r2, r1, "R4 bit31 flipped");
    issue(1, 1, 32'hCEC0_8400, r2, r1, "R4 near miss");
    issue(0, 1, OPC | 32'h11, r2, r1, "R7 idle");
    issue(1, 1, OPC | 32'h2A5, r2, r1, "R5 indices");

    for (int i = 0; i < 300; i++) begin
      logic [31:0] w;
      int sel;
      sel = $urandom_range(0, 9);
      w = (sel < 7) ? (OPC | ($urandom & 32'h3FF)) : $urandom;
      issue($urandom_range(0, 7) != 0, $urandom_range(0, 5) != 0, w,
            {$urandom, $urandom, $urandom, $urandom},
            {$urandom, $urandom, $urandom, $urandom}, "R1 R2 R6 random");
    end

    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk("R8 mid-run reset", {res_data[125:0], res_valid, res_undef}, 128'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule